// File: doc/BRIEF.md
# Exception and Reset Entry Sequencer

This block produces the bus-cycle program a CPU core with 24-bit addressing runs when it enters an exception handler: a hardware interrupt, a non-maskable interrupt, an abort, a software break, a coprocessor trap, or a reset. The core pulses `start` and supplies the exception kind, the emulation flag, the program bank, the 16-bit PC, the status byte and the stack pointer. The block then issues one bus cycle per clock. It saves the return context on the stack, reads a 16-bit handler address from a vector slot, and returns the new PC, stack pointer, status byte and program bank.

The vector slot is chosen only after the PC has been saved and before the status byte goes out. A non-maskable interrupt that arrives while the save is in progress can therefore still take the vector. A reset runs the same cycles with the stack accesses turned into reads. The stack pointer moves as usual, but memory is never written.

Top module: `exc_entry_seq`

## Requirements
- R1: For kinds IRQ (0), NMI (1), ABORT (2) and RESET (5), and any undefined code (6, 7, treated as IRQ), the first two cycles after `start` are reads (`bus_rd`=1, `bus_wr`=0) at address {pbank, pc}.
- R2: For BRK (3) and COP (4), the two dummy reads are replaced by a single read at {pbank, pc}, and the PC that is saved is pc+1 modulo 2^16. The bank is not incremented.
- R3: In native mode (`emu`=0), the saves are the program bank, then PC[15:8], then PC[7:0], then the status byte. Each is written at {8'h00, sp}, and sp decrements by one after each save, modulo 2^16.
- R4: In emulation mode (`emu`=1), the program-bank save is left out. Stack addresses are {8'h00, 8'h01, low}, where the low byte decrements and wraps from 00 to FF while the high byte stays 01.
- R5: A RESET issues the same cycles at the same addresses as another exception. Every stack cycle has `bus_rd`=1 and `bus_wr` is never asserted.
- R6: Vector addresses for native mode / emulation mode are: IRQ FFEE/FFFE, NMI FFEA/FFFA, ABORT FFE8/FFF8, BRK FFE6/FFFE, COP FFE4/FFF4, RESET FFFC/FFFC.
- R7: `late_nmi`, sampled on the clock edge that ends the PC[7:0] save cycle, makes the sequence use the NMI vector for any kind except RESET. For RESET it has no effect.
- R8: After the status save, the block reads {8'h00, vec}, then {8'h00, vec+1}. The new PC is {second byte, first byte}.
- R9: In the cycle after the vector's high-byte read, `done` is 1 for exactly one cycle. In that cycle, `new_pbank` is 0 and `new_sp` is the stack pointer after the last save. `new_status` is the status input with bit 2 (interrupt disable) set and bit 3 (decimal) cleared.
- R10: After reset, `busy`, `done`, `bus_rd` and `bus_wr` are 0. A `start` pulse that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an entry sequence (taken only when idle) |
| kind | input | 3 | Exception kind code |
| emu | input | 1 | Emulation mode flag |
| pbank | input | 8 | Current program bank |
| pc | input | 16 | Current program counter |
| status | input | 8 | Status byte to save |
| sp | input | 16 | Current stack pointer |
| late_nmi | input | 1 | Late non-maskable request, sampled at vector choice |
| bus_rdata | input | 8 | Read data from memory |
| busy | output | 1 | Sequence in progress |
| bus_rd | output | 1 | Read cycle this clock |
| bus_wr | output | 1 | Write cycle this clock |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler address |
| new_pbank | output | 8 | New program bank (zero) |
| new_sp | output | 16 | Stack pointer after the saves |
| new_status | output | 8 | Status after entry |

## Verification
The bench goes after the stack-pointer wrap points: native sp 0x0001 down through 0xFFFE, and emulation sp 0x0101 down into 0x01FF. A design that borrowed into the high byte in emulation would write outside page one. Late NMI is raised both during an IRQ and during a reset. A design that picked the vector too early would keep the IRQ slot, and one that ignored priority would steer a reset to the NMI handler. A break taken at PC 0xFFFF checks that the saved PC wraps within its own bank. Mid-run `start` pulses and reset runs check that a sequence cannot be restarted and that a reset never writes memory.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [2:0] {
      EK_IRQ   = 3'd0,
      EK_NMI   = 3'd1,
      EK_ABORT = 3'd2,
      EK_BRK   = 3'd3,
      EK_COP   = 3'd4,
      EK_RESET = 3'd5
   } exc_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DUM1,
      ST_DUM2,
      ST_SIG,
      ST_SV_BANK,
      ST_SV_PCH,
      ST_SV_PCL,
      ST_SV_STAT,
      ST_VEC_LO,
      ST_VEC_HI,
      ST_FIN
   } step_e;

   function automatic logic [15:0] slot_addr(input logic [2:0] k, input logic e);
      logic [15:0] a;
      case (k)
         EK_RESET: a = 16'hFFFC;
         EK_NMI:   a = e ? 16'hFFFA : 16'hFFEA;
         EK_ABORT: a = e ? 16'hFFF8 : 16'hFFE8;
         EK_BRK:   a = e ? 16'hFFFE : 16'hFFE6;
         EK_COP:   a = e ? 16'hFFF4 : 16'hFFE4;
         default:  a = e ? 16'hFFFE : 16'hFFEE;
      endcase
      return a;
   endfunction

   function automatic logic is_saving(input step_e s);
      return (s == ST_SV_BANK) || (s == ST_SV_PCH) ||
             (s == ST_SV_PCL)  || (s == ST_SV_STAT);
   endfunction

endpackage

// File: rtl/exc_vec_pick.sv
module exc_vec_pick
   import exc_entry_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic [2:0]      kind,
   input  logic            emu,
   input  logic            late_nmi,
   output logic [PC_W-1:0] vec
);
   logic [2:0] eff_kind;

   // Priority: reset first, then a non-maskable request, then the latched kind.
   always_comb begin
      if (kind == EK_RESET)       eff_kind = EK_RESET;
      else if (late_nmi)          eff_kind = EK_NMI;
      else                        eff_kind = kind;
   end

   generate
      if (PC_W == 16) begin : g_std
         assign vec = slot_addr(eff_kind, emu);
      end else begin : g_wide
         assign vec = {{(PC_W-16){1'b1}}, slot_addr(eff_kind, emu)};
      end
   endgenerate
endmodule

// File: rtl/exc_stack_ptr.sv
module exc_stack_ptr #(
   parameter int          SP_W     = 16,
   parameter logic [7:0]  EMU_PAGE = 8'h01
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SP_W-1:0] load_val,
   input  logic            emu,
   input  logic            dec,
   output logic [SP_W-1:0] sp_q
);
   logic [SP_W-1:0] load_fmt;
   logic [SP_W-1:0] dec_val;

   generate
      if (SP_W > 8) begin : g_paged
         // Emulation keeps the high byte pinned to its page; only the low byte moves.
         assign load_fmt = emu ? {{(SP_W-16){1'b0}}, EMU_PAGE, load_val[7:0]} : load_val;
         assign dec_val  = emu ? {{(SP_W-16){1'b0}}, EMU_PAGE, sp_q[7:0] - 8'd1}
                               : sp_q - 1'b1;
      end else begin : g_flat
         assign load_fmt = load_val;
         assign dec_val  = sp_q - 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp_q <= '0;
      else if (load)  sp_q <= load_fmt;
      else if (dec)   sp_q <= dec_val;
   end

   assert_sp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (sp_q[7:0] == $past(sp_q[7:0]) - 8'd1));

   assert_emu_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && emu) |=> (sp_q[15:8] == EMU_PAGE));
endmodule

// File: rtl/exc_step_ctrl.sv
module exc_step_ctrl
   import exc_entry_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] kind,
   input  logic       emu_q,
   output step_e      state,
   output logic       accept
);
   step_e nxt;
   logic  sw_kind;

   assign sw_kind = (kind == EK_BRK) || (kind == EK_COP);
   assign accept  = (state == ST_IDLE) && start;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:    if (start) nxt = sw_kind ? ST_SIG : ST_DUM1;
         ST_DUM1:    nxt = ST_DUM2;
         ST_DUM2:    nxt = emu_q ? ST_SV_PCH : ST_SV_BANK;
         ST_SIG:     nxt = emu_q ? ST_SV_PCH : ST_SV_BANK;
         ST_SV_BANK: nxt = ST_SV_PCH;
         ST_SV_PCH:  nxt = ST_SV_PCL;
         ST_SV_PCL:  nxt = ST_SV_STAT;
         ST_SV_STAT: nxt = ST_VEC_LO;
         ST_VEC_LO:  nxt = ST_VEC_HI;
         ST_VEC_HI:  nxt = ST_FIN;
         ST_FIN:     nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assert_emu_skip_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SV_BANK) |-> !emu_q);

   assert_fin_after_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_VEC_HI) |=> (state == ST_FIN));

   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_FIN) |=> (state != ST_IDLE));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int         BANK_W   = 8,
   parameter int         PC_W     = 16,
   parameter int         DATA_W   = 8,
   parameter logic [7:0] EMU_PAGE = 8'h01
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [2:0]               kind,
   input  logic                     emu,
   input  logic [BANK_W-1:0]        pbank,
   input  logic [PC_W-1:0]          pc,
   input  logic [DATA_W-1:0]        status,
   input  logic [PC_W-1:0]          sp,
   input  logic                     late_nmi,
   input  logic [DATA_W-1:0]        bus_rdata,
   output logic                     busy,
   output logic                     bus_rd,
   output logic                     bus_wr,
   output logic [BANK_W+PC_W-1:0]   bus_addr,
   output logic [DATA_W-1:0]        bus_wdata,
   output logic                     done,
   output logic [PC_W-1:0]          new_pc,
   output logic [BANK_W-1:0]        new_pbank,
   output logic [PC_W-1:0]          new_sp,
   output logic [DATA_W-1:0]        new_status
);
   localparam int ADDR_W = BANK_W + PC_W;
   localparam int BIT_I  = 2;
   localparam int BIT_D  = 3;

   initial begin
      assert (PC_W == 2*DATA_W) else $error("PC must be two data bytes wide");
      assert (BANK_W == DATA_W) else $error("bank must be one data byte wide");
   end

   step_e             state;
   logic              accept;
   logic [2:0]        kind_q;
   logic              emu_q;
   logic [BANK_W-1:0] pb_q;
   logic [PC_W-1:0]   pc_q;
   logic [DATA_W-1:0] st_q;
   logic [PC_W-1:0]   vec_q;
   logic [PC_W-1:0]   vec_pick;
   logic [DATA_W-1:0] vlo_q;
   logic [PC_W-1:0]   sp_q;
   logic              is_reset;
   logic              saving;

   exc_step_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .kind   (kind),
      .emu_q  (emu_q),
      .state  (state),
      .accept (accept)
   );

   exc_vec_pick #(.PC_W(PC_W)) u_pick (
      .kind     (kind_q),
      .emu      (emu_q),
      .late_nmi (late_nmi),
      .vec      (vec_pick)
   );

   assign saving   = is_saving(state);
   assign is_reset = (kind_q == EK_RESET);

   exc_stack_ptr #(.SP_W(PC_W), .EMU_PAGE(EMU_PAGE)) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (sp),
      .emu      (accept ? emu : emu_q),
      .dec      (saving),
      .sp_q     (sp_q)
   );

   // Context capture and handler address assembly.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= '0;
         emu_q  <= 1'b0;
         pb_q   <= '0;
         pc_q   <= '0;
         st_q   <= '0;
         vec_q  <= '0;
         vlo_q  <= '0;
         new_pc <= '0;
      end else begin
         if (accept) begin
            kind_q <= kind;
            emu_q  <= emu;
            pb_q   <= pbank;
            pc_q   <= pc;
            st_q   <= status;
         end
         if (state == ST_SIG)    pc_q   <= pc_q + 1'b1;
         if (state == ST_SV_PCL) vec_q  <= vec_pick;
         if (state == ST_VEC_LO) vlo_q  <= bus_rdata;
         if (state == ST_VEC_HI) new_pc <= {bus_rdata, vlo_q};
      end
   end

   // Bus cycle decode.
   always_comb begin
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      case (state)
         ST_DUM1, ST_DUM2, ST_SIG: begin
            bus_rd   = 1'b1;
            bus_addr = {pb_q, pc_q};
         end
         ST_SV_BANK, ST_SV_PCH, ST_SV_PCL, ST_SV_STAT: begin
            bus_rd   = is_reset;
            bus_wr   = !is_reset;
            bus_addr = {{BANK_W{1'b0}}, sp_q};
            case (state)
               ST_SV_BANK: bus_wdata = pb_q;
               ST_SV_PCH:  bus_wdata = pc_q[PC_W-1:DATA_W];
               ST_SV_PCL:  bus_wdata = pc_q[DATA_W-1:0];
               default:    bus_wdata = st_q;
            endcase
         end
         ST_VEC_LO: begin
            bus_rd   = 1'b1;
            bus_addr = {{BANK_W{1'b0}}, vec_q};
         end
         ST_VEC_HI: begin
            bus_rd   = 1'b1;
            bus_addr = {{BANK_W{1'b0}}, vec_q + 1'b1};
         end
         default: ;
      endcase
   end

   always_comb begin
      new_status        = st_q;
      new_status[BIT_I] = 1'b1;
      new_status[BIT_D] = 1'b0;
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign new_pbank = '0;
   assign new_sp    = sp_q;

   assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   assert_reset_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_reset) |-> !bus_wr);

   assert_late_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SV_PCL && late_nmi && !is_reset) |=>
         (vec_q == (emu_q ? 16'hFFFA : 16'hFFEA)));

   assert_vec_bank0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_VEC_LO || state == ST_VEC_HI) |-> (bus_addr[ADDR_W-1:PC_W] == '0));

   assert_handler_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_VEC_HI) |=> (new_pc == {$past(bus_rdata), vlo_q}));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  kind = '0;
   logic        emu = 1'b0;
   logic [7:0]  pbank = '0;
   logic [15:0] pc = '0;
   logic [7:0]  status = '0;
   logic [15:0] sp = '0;
   logic        late_nmi = 1'b0;
   logic [7:0]  bus_rdata = '0;
   logic        busy, bus_rd, bus_wr, done;
   logic [23:0] bus_addr;
   logic [7:0]  bus_wdata, new_pbank, new_status;
   logic [15:0] new_pc, new_sp;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   exc_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .emu(emu),
      .pbank(pbank), .pc(pc), .status(status), .sp(sp), .late_nmi(late_nmi),
      .bus_rdata(bus_rdata), .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done), .new_pc(new_pc),
      .new_pbank(new_pbank), .new_sp(new_sp), .new_status(new_status)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_vec(input int k, input bit e);
      case (k)
         5: return 16'hFFFC;
         1: return e ? 16'hFFFA : 16'hFFEA;
         2: return e ? 16'hFFF8 : 16'hFFE8;
         3: return e ? 16'hFFFE : 16'hFFE6;
         4: return e ? 16'hFFF4 : 16'hFFE4;
         default: return e ? 16'hFFFE : 16'hFFEE;
      endcase
   endfunction

   task automatic run(input int k, input bit e, input logic [7:0] pb,
                      input logic [15:0] p, input logic [7:0] st,
                      input logic [15:0] s, input bit late,
                      input logic [7:0] vlo, input logic [7:0] vhi, input bit poke);
      logic        x_rd [12];
      logic        x_wr [12];
      logic [23:0] x_ad [12];
      logic [7:0]  x_wd [12];
      string       x_tg [12];
      int          n = 0;
      int          pcl_i = 0;
      int          vlo_i;
      int          err0 = errors;
      logic [15:0] pcs;
      logic [15:0] spx;
      logic [15:0] vec;
      bit          rst_kind = (k == 5);
      bit          sw = (k == 3 || k == 4);
      // Expected cycle program.
      if (sw) begin
         x_rd[n] = 1; x_wr[n] = 0; x_ad[n] = {pb, p}; x_wd[n] = 0; x_tg[n] = "R2"; n++;
         pcs = p + 16'd1;
      end else begin
         for (int d = 0; d < 2; d++) begin
            x_rd[n] = 1; x_wr[n] = 0; x_ad[n] = {pb, p}; x_wd[n] = 0; x_tg[n] = "R1"; n++;
         end
         pcs = p;
      end
      spx = e ? {8'h01, s[7:0]} : s;
      for (int j = 0; j < 4; j++) begin
         if (!(j == 0 && e)) begin
            x_rd[n] = rst_kind; x_wr[n] = !rst_kind; x_ad[n] = {8'h00, spx};
            x_wd[n] = (j == 0) ? pb : (j == 1) ? pcs[15:8] : (j == 2) ? pcs[7:0] : st;
            x_tg[n] = rst_kind ? "R5" : (e ? "R4" : "R3");
            if (j == 2) pcl_i = n;
            n++;
            spx = e ? {8'h01, spx[7:0] - 8'd1} : spx - 16'd1;
         end
      end
      vec = ref_vec((late && !rst_kind) ? 1 : k, e);
      vlo_i = n;
      x_rd[n] = 1; x_wr[n] = 0; x_ad[n] = {8'h00, vec}; x_wd[n] = 0;
      x_tg[n] = late ? "R7" : "R6"; n++;
      x_rd[n] = 1; x_wr[n] = 0; x_ad[n] = {8'h00, vec + 16'd1}; x_wd[n] = 0; x_tg[n] = "R8"; n++;

      @(negedge clk);
      kind = k[2:0]; emu = e; pbank = pb; pc = p; status = st; sp = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // Inputs now change so the block must rely on its captured copies.
      pc = ~p; sp = ~s; status = ~st; pbank = ~pb; emu = ~e;
      for (int i = 0; i < n; i++) begin
         chk({bus_rd, bus_wr, bus_addr} == {x_rd[i], x_wr[i], x_ad[i]},
             $sformatf("%s cycle %0d rd/wr/addr", x_tg[i], i),
             {6'd0, bus_rd, bus_wr, bus_addr}, {6'd0, x_rd[i], x_wr[i], x_ad[i]});
         if (x_wr[i] || (x_rd[i] && i >= vlo_i - 4 && i < vlo_i && !rst_kind))
            chk(bus_wdata == x_wd[i], $sformatf("%s cycle %0d data", x_tg[i], i),
                {24'd0, bus_wdata}, {24'd0, x_wd[i]});
         late_nmi  = (i == pcl_i) ? late : 1'b0;
         start     = (poke && i == 1);
         if (poke && i == 1) kind = 3'd5;
         bus_rdata = (i == vlo_i) ? vlo : (i == vlo_i + 1) ? vhi : 8'hA5;
         @(negedge clk);
      end
      start = 1'b0;
      late_nmi = 1'b0;
      chk(done == 1'b1 && busy == 1'b1, "R9 done pulse", {31'd0, done}, 32'd1);
      chk(new_pc == {vhi, vlo}, "R8 new pc", {16'd0, new_pc}, {16'd0, vhi, vlo});
      chk(new_sp == spx, "R9 new sp", {16'd0, new_sp}, {16'd0, spx});
      chk(new_status == ((st | 8'h04) & 8'hF7), "R9 new status",
          {24'd0, new_status}, {24'd0, (st | 8'h04) & 8'hF7});
      chk(new_pbank == 8'h00, "R9 new bank", {24'd0, new_pbank}, 32'd0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R9 single pulse then idle",
          {30'd0, done, busy}, 32'd0);
      if (poke)
         chk(errors == err0, "R10 start while busy ignored", errors - err0, 0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1D));
      repeat (3) @(negedge clk);
      chk({busy, done, bus_rd, bus_wr} == 4'b0, "R10 reset state",
          {28'd0, busy, done, bus_rd, bus_wr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, bus_rd, bus_wr} == 4'b0, "R10 idle after reset",
          {28'd0, busy, done, bus_rd, bus_wr}, 32'd0);
      // Directed corners: every kind in both modes.
      for (int k = 0; k < 8; k++)
         for (int e = 0; e < 2; e++)
            run(k, e[0], 8'h12, 16'h3456, 8'h5A, 16'h01F0, 1'b0, 8'h34, 8'h12, 1'b0);
      run(0, 0, 8'h7E, 16'h8000, 8'hFF, 16'h0001, 1'b1, 8'hCD, 8'hAB, 1'b0); // R7 native, sp wrap R3
      run(0, 1, 8'h00, 16'hC000, 8'h08, 16'h0101, 1'b1, 8'h11, 8'h22, 1'b0); // R7 emu, page wrap R4
      run(5, 0, 8'h33, 16'h1234, 8'h00, 16'h0002, 1'b1, 8'h00, 8'hE0, 1'b0); // R7 ignored on reset
      run(3, 0, 8'h44, 16'hFFFF, 8'h0C, 16'h1FFF, 1'b0, 8'h55, 8'h66, 1'b0); // R2 pc wrap
      run(4, 1, 8'h01, 16'h00FF, 8'h30, 16'h0100, 1'b0, 8'h77, 8'h88, 1'b1); // R10 poke
      // Constrained random.
      for (int r = 0; r < 300; r++) begin
         int k = int'($urandom_range(0, 7));
         run(k, 1'($urandom), 8'($urandom), 16'($urandom), 8'($urandom), 16'($urandom),
             ($urandom_range(0, 3) == 0), 8'($urandom), 8'($urandom),
             ($urandom_range(0, 7) == 0));
      end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule